// File: doc/BRIEF.md
# DMA Command Splitter with Per-Tag Completion Tracking

This block takes one DMA command at a time and turns it into packets for an on-chip interconnect. A command carries a local-store address, a system address, a byte count, a direction bit and a 5-bit tag. The block first checks the byte count and the alignment of both addresses. A command that fails is dropped, and a one-cycle error pulse reports it. A command that passes is cut into packets of at most 128 bytes. The packets leave on a valid/ready interface with both addresses advancing, and the final packet is marked. Consecutive packet handshakes are kept at least eight cycles apart, which models the bus occupancy of a single transfer.

Every tag has an outstanding-packet counter. The counter goes up when a packet of that tag is handed off and down when the fabric acknowledges a packet of that tag. Software can poll a 32-bit vector that shows which tags have nothing outstanding. It can also block: it presents a tag mask on a wait port, and the wait's ready rises only once every masked tag has drained.

Top module: `dma_cmd_splitter`

## Requirements
- R1: A command is legal only if its size is 1, 2, 4 or 8, or a non-zero multiple of 16 no larger than 16384. An illegal command is consumed and produces no packet. `cmdErr` is high for exactly the one cycle after the accepting edge. `cmdReady` stays high.
- R2: Alignment is checked on both the local and the system address. For sizes 1, 2, 4 and 8, each address must be a multiple of the size. For sizes of 16 and above, the low four bits of each address must be zero. A command that breaks this rule is rejected as in R1.
- R3: A legal command of N bytes is issued as ceil(N/128) packets. Every packet carries 128 bytes except the last, which carries the remainder in the range 1..128. Both addresses rise by 128 from one packet to the next. `pktLast` is 1 only on the final packet.
- R4: Two packet handshakes (`pktValid && pktReady` at a rising edge) are never closer than 8 clock edges apart, even across command boundaries.
- R5: Only one command is handled at a time. `cmdReady` is low from the edge that accepts a legal command until the edge of its final packet handshake. It is high again in the following cycle. `cmdReady` and `pktValid` are never high together.
- R6: While `pktValid` is high and `pktReady` is low, `pktValid` and all packet fields hold their values.
- R7: Each tag has a counter. A packet handshake of that tag raises it by one. `ackValid` with that `ackTag` lowers it by one. An acknowledge to a tag whose count is zero is ignored. When a handshake and an acknowledge hit the same tag in the same cycle, the count does not change. Bit t of `tagIdle` is 1 exactly when the count of tag t is zero, and it updates in the cycle after the edge.
- R8: `waitReady` equals `waitValid` AND (every tag whose bit is set in `waitMask` has its `tagIdle` bit set). It is combinational, in the same cycle.
- R9: If 8 edges have passed since the previous packet handshake, the first packet of a legal command is valid in the cycle right after the accepting edge. Each packet carries the command's tag and direction.
- R10: During and after reset, `cmdReady` is 1, `pktValid` is 0, `cmdErr` is 0 and `tagIdle` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block can take a command |
| cmdLocalAddr | input | 18 | Local-store byte address |
| cmdSysAddr | input | 32 | System byte address |
| cmdSize | input | 15 | Transfer size in bytes |
| cmdWrite | input | 1 | Direction: 1 = local to system |
| cmdTag | input | 5 | Completion tag |
| cmdErr | output | 1 | One-cycle pulse for a rejected command |
| pktValid | output | 1 | Packet offered |
| pktReady | input | 1 | Interconnect takes the packet |
| pktLocalAddr | output | 18 | Packet local address |
| pktSysAddr | output | 32 | Packet system address |
| pktBytes | output | 8 | Packet length, 1..128 |
| pktWrite | output | 1 | Packet direction |
| pktTag | output | 5 | Packet tag |
| pktLast | output | 1 | Final packet of the command |
| ackValid | input | 1 | A packet has completed |
| ackTag | input | 5 | Tag of the completed packet |
| tagIdle | output | 32 | Per-tag no-outstanding flags |
| waitValid | input | 1 | Blocking wait presented |
| waitMask | input | 32 | Tags the wait covers |
| waitReady | output | 1 | All covered tags are idle |

## Verification
Each result has its own due cycle:
- The error pulse, the drop of `cmdReady` and the first `pktValid` are registered results. They are due in the cycle after the edge that takes the command.
- `tagIdle` changes in the cycle after the packet-handshake edge or the acknowledge edge that moves the count.
- `waitReady` follows `waitMask` and `tagIdle` in the same cycle.
- Packet spacing means the next `pktValid` is due eight edges after the previous handshake.

The bench advances its reference model at each rising edge, using the inputs that were present at that edge. It then compares every output a short delay after the edge. This way each result is checked in exactly the cycle it is due, and inputs change only at falling edges.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } splitState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;  // capture a legal command
    logic stepPkt;  // a packet was handed off
  } splitStrobe_t;

endpackage

// File: rtl/dma_split_ctrl.sv
module dma_split_ctrl
  import dma_split_pkg::*;
#(
  parameter int SIZE_W   = 15,
  parameter int GAP      = 8,
  parameter int MAX_SIZE = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  input  logic [SIZE_W-1:0] cmdSize,
  input  logic [3:0]        cmdLocalLow,
  input  logic [3:0]        cmdSysLow,
  input  logic              pktReady,
  input  logic              lastPkt,
  output logic              cmdReady,
  output logic              pktValid,
  output logic              cmdErr,
  output splitStrobe_t      strobe
);

  localparam int GAP_W = (GAP > 1) ? $clog2(GAP) : 1;

  splitState_t       state, stateNext;
  logic [GAP_W-1:0]  gapCnt;
  logic              smallSize, bigSize, alignOk, cmdLegal, cmdTake;
  logic [3:0]        alignMask;

  always_comb begin
    smallSize = (cmdSize == SIZE_W'(1)) || (cmdSize == SIZE_W'(2)) ||
                (cmdSize == SIZE_W'(4)) || (cmdSize == SIZE_W'(8));
    bigSize   = (cmdSize[3:0] == 4'd0) && (cmdSize != '0) &&
                (cmdSize <= SIZE_W'(MAX_SIZE));
    alignMask = smallSize ? (cmdSize[3:0] - 4'd1) : 4'hF;
    alignOk   = ((cmdLocalLow | cmdSysLow) & alignMask) == 4'd0;
    cmdLegal  = (smallSize || bigSize) && alignOk;
  end

  assign cmdReady       = (state == ST_IDLE);
  assign pktValid       = (state == ST_BUSY) && (gapCnt == '0);
  assign cmdTake        = cmdValid && cmdReady;
  assign strobe.loadCmd = cmdTake && cmdLegal;
  assign strobe.stepPkt = pktValid && pktReady;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strobe.loadCmd) stateNext = ST_BUSY;
      ST_BUSY: if (strobe.stepPkt && lastPkt) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      gapCnt <= '0;
      cmdErr <= 1'b0;
    end else begin
      state  <= stateNext;
      cmdErr <= cmdTake && !cmdLegal;
      if (strobe.stepPkt)
        gapCnt <= GAP_W'(GAP - 1);
      else if (gapCnt != '0)
        gapCnt <= gapCnt - GAP_W'(1);
    end
  end

endmodule

// File: rtl/dma_split_dp.sv
module dma_split_dp
  import dma_split_pkg::*;
#(
  parameter int LADDR_W   = 18,
  parameter int SADDR_W   = 32,
  parameter int SIZE_W    = 15,
  parameter int TAG_W     = 5,
  parameter int PKT_BYTES = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  splitStrobe_t                  strobe,
  input  logic [LADDR_W-1:0]            cmdLocalAddr,
  input  logic [SADDR_W-1:0]            cmdSysAddr,
  input  logic [SIZE_W-1:0]             cmdSize,
  input  logic                          cmdWrite,
  input  logic [TAG_W-1:0]              cmdTag,
  output logic [LADDR_W-1:0]            pktLocalAddr,
  output logic [SADDR_W-1:0]            pktSysAddr,
  output logic [$clog2(PKT_BYTES):0]    pktBytes,
  output logic                          pktWrite,
  output logic [TAG_W-1:0]              pktTag,
  output logic                          lastPkt
);

  localparam int PKT_W = $clog2(PKT_BYTES) + 1;

  logic [SIZE_W-1:0] remain;

  assign lastPkt  = (remain <= SIZE_W'(PKT_BYTES));
  assign pktBytes = lastPkt ? remain[PKT_W-1:0] : PKT_W'(PKT_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain       <= '0;
      pktLocalAddr <= '0;
      pktSysAddr   <= '0;
      pktWrite     <= 1'b0;
      pktTag       <= '0;
    end else if (strobe.loadCmd) begin
      remain       <= cmdSize;
      pktLocalAddr <= cmdLocalAddr;
      pktSysAddr   <= cmdSysAddr;
      pktWrite     <= cmdWrite;
      pktTag       <= cmdTag;
    end else if (strobe.stepPkt) begin
      remain       <= remain - SIZE_W'(PKT_BYTES);
      pktLocalAddr <= pktLocalAddr + LADDR_W'(PKT_BYTES);
      pktSysAddr   <= pktSysAddr + SADDR_W'(PKT_BYTES);
    end
  end

endmodule

// File: rtl/dma_tag_track.sv
module dma_tag_track #(
  parameter int TAG_W = 5,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issueFire,
  input  logic [TAG_W-1:0]      issueTag,
  input  logic                  ackValid,
  input  logic [TAG_W-1:0]      ackTag,
  input  logic                  waitValid,
  input  logic [(1<<TAG_W)-1:0] waitMask,
  output logic [(1<<TAG_W)-1:0] tagIdle,
  output logic                  waitReady
);

  localparam int NUM_TAGS = 1 << TAG_W;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : gTag
    logic [CNT_W-1:0] cnt;
    logic incHit, decHit;

    assign incHit     = issueFire && (issueTag == TAG_W'(g));
    assign decHit     = ackValid && (ackTag == TAG_W'(g)) && (cnt != '0);
    assign tagIdle[g] = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt <= '0;
      else if (incHit && !decHit)
        cnt <= cnt + CNT_W'(1);
      else if (decHit && !incHit)
        cnt <= cnt - CNT_W'(1);
    end
  end

  assign waitReady = waitValid && ((waitMask & ~tagIdle) == '0);

endmodule

// File: rtl/dma_cmd_splitter.sv
module dma_cmd_splitter
  import dma_split_pkg::*;
#(
  parameter int LADDR_W   = 18,
  parameter int SADDR_W   = 32,
  parameter int SIZE_W    = 15,
  parameter int TAG_W     = 5,
  parameter int CNT_W     = 8,
  parameter int PKT_BYTES = 128,
  parameter int GAP       = 8,
  parameter int MAX_SIZE  = 16384
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmdValid,
  output logic                         cmdReady,
  input  logic [LADDR_W-1:0]           cmdLocalAddr,
  input  logic [SADDR_W-1:0]           cmdSysAddr,
  input  logic [SIZE_W-1:0]            cmdSize,
  input  logic                         cmdWrite,
  input  logic [TAG_W-1:0]             cmdTag,
  output logic                         cmdErr,
  output logic                         pktValid,
  input  logic                         pktReady,
  output logic [LADDR_W-1:0]           pktLocalAddr,
  output logic [SADDR_W-1:0]           pktSysAddr,
  output logic [$clog2(PKT_BYTES):0]   pktBytes,
  output logic                         pktWrite,
  output logic [TAG_W-1:0]             pktTag,
  output logic                         pktLast,
  input  logic                         ackValid,
  input  logic [TAG_W-1:0]             ackTag,
  output logic [(1<<TAG_W)-1:0]        tagIdle,
  input  logic                         waitValid,
  input  logic [(1<<TAG_W)-1:0]        waitMask,
  output logic                         waitReady
);

  splitStrobe_t strobe;
  logic         lastPkt;

  dma_split_ctrl #(
    .SIZE_W(SIZE_W), .GAP(GAP), .MAX_SIZE(MAX_SIZE)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdSize(cmdSize),
    .cmdLocalLow(cmdLocalAddr[3:0]), .cmdSysLow(cmdSysAddr[3:0]),
    .pktReady(pktReady), .lastPkt(lastPkt), .cmdReady(cmdReady),
    .pktValid(pktValid), .cmdErr(cmdErr), .strobe(strobe)
  );

  dma_split_dp #(
    .LADDR_W(LADDR_W), .SADDR_W(SADDR_W), .SIZE_W(SIZE_W),
    .TAG_W(TAG_W), .PKT_BYTES(PKT_BYTES)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cmdLocalAddr(cmdLocalAddr),
    .cmdSysAddr(cmdSysAddr), .cmdSize(cmdSize), .cmdWrite(cmdWrite),
    .cmdTag(cmdTag), .pktLocalAddr(pktLocalAddr), .pktSysAddr(pktSysAddr),
    .pktBytes(pktBytes), .pktWrite(pktWrite), .pktTag(pktTag),
    .lastPkt(lastPkt)
  );

  assign pktLast = lastPkt;

  dma_tag_track #(
    .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) track_i (
    .clk(clk), .rst_n(rst_n), .issueFire(strobe.stepPkt), .issueTag(pktTag),
    .ackValid(ackValid), .ackTag(ackTag), .waitValid(waitValid),
    .waitMask(waitMask), .tagIdle(tagIdle), .waitReady(waitReady)
  );

endmodule

// File: rtl/dma_cmd_splitter_chk.sv
module dma_cmd_splitter_chk #(
  parameter int LADDR_W   = 18,
  parameter int SADDR_W   = 32,
  parameter int TAG_W     = 5,
  parameter int PKT_BYTES = 128,
  parameter int GAP       = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmdValid,
  input logic                       cmdReady,
  input logic                       cmdErr,
  input logic                       pktValid,
  input logic                       pktReady,
  input logic [LADDR_W-1:0]         pktLocalAddr,
  input logic [SADDR_W-1:0]         pktSysAddr,
  input logic [$clog2(PKT_BYTES):0] pktBytes,
  input logic [TAG_W-1:0]           pktTag,
  input logic                       pktLast,
  input logic                       ackValid,
  input logic [TAG_W-1:0]           ackTag,
  input logic [(1<<TAG_W)-1:0]      tagIdle,
  input logic                       waitValid,
  input logic [(1<<TAG_W)-1:0]      waitMask,
  input logic                       waitReady
);

  logic        fire;
  logic [15:0] sinceFire;

  assign fire = pktValid && pktReady;

  // cycles elapsed since the previous handshake, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sinceFire <= 16'(GAP - 1);
    else if (fire)
      sinceFire <= '0;
    else if (sinceFire != 16'hFFFF)
      sinceFire <= sinceFire + 16'd1;
  end

  assert_err_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmdErr |-> $past(cmdValid && cmdReady));

  assert_pkt_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid |-> (pktBytes != '0) && (pktBytes <= PKT_BYTES));

  assert_last_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pktLast) |=> cmdReady);

  assert_pkt_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (sinceFire >= 16'(GAP - 1)));

  assert_single_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmdReady && pktValid));

  assert_pkt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pktValid && !pktReady) |=> pktValid && $stable(pktBytes) &&
      $stable(pktLocalAddr) && $stable(pktSysAddr) && $stable(pktTag));

  assert_tag_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(ackValid && ackTag == pktTag)) |=> !tagIdle[$past(pktTag)]);

  assert_wait_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    waitReady |-> waitValid && ((tagIdle & waitMask) == waitMask));

endmodule

bind dma_cmd_splitter dma_cmd_splitter_chk #(
  .LADDR_W(LADDR_W), .SADDR_W(SADDR_W), .TAG_W(TAG_W),
  .PKT_BYTES(PKT_BYTES), .GAP(GAP)
) chk_i (.*);

// File: tb/dma_cmd_splitter_tb_top.sv
module dma_cmd_splitter_tb_top;

  localparam int TAGS = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmdValid, cmdReady, cmdWrite, cmdErr;
  logic [17:0] cmdLocalAddr;
  logic [31:0] cmdSysAddr;
  logic [14:0] cmdSize;
  logic [4:0]  cmdTag;
  logic        pktValid, pktReady, pktWrite, pktLast;
  logic [17:0] pktLocalAddr;
  logic [31:0] pktSysAddr;
  logic [7:0]  pktBytes;
  logic [4:0]  pktTag;
  logic        ackValid;
  logic [4:0]  ackTag;
  logic [31:0] tagIdle, waitMask;
  logic        waitValid, waitReady;

  always #5 clk = ~clk;

  dma_cmd_splitter dut_i (.*);

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // reference model state
  bit mBusy, mWrite, mErr;
  int mRem, mLaddr, mSaddr, mTag, mGap;
  int mCnt[TAGS];
  int tagQ[$];

  bit ackOn = 0;
  int spurTag = -1;
  int readyMode = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit legalCmd(int size, int la, int sa);
    if (size == 1 || size == 2 || size == 4 || size == 8)
      return (la % size == 0) && (sa % size == 0);
    if (size >= 16 && size <= 16384 && size % 16 == 0)
      return (la % 16 == 0) && (sa % 16 == 0);
    return 0;
  endfunction

  // model step at each edge, compare shortly after it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog R5 actual=%0d expected<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
      if (!rst_n) begin
        mBusy = 0; mErr = 0; mGap = 0; mRem = 0;
        foreach (mCnt[i]) mCnt[i] = 0;
      end else begin
        bit pv, fire, acc;
        int idleExp;
        pv   = mBusy && (mGap == 0);
        fire = pv && pktReady;
        acc  = cmdValid && !mBusy;
        if (ackValid && mCnt[ackTag] > 0) mCnt[ackTag]--;
        if (fire) begin
          mCnt[mTag]++;
          tagQ.push_back(mTag);
        end
        if (fire) mGap = 7; else if (mGap > 0) mGap--;
        if (fire) begin
          if (mRem <= 128) mBusy = 0;
          else begin mRem -= 128; mLaddr += 128; mSaddr += 128; end
        end
        mErr = 0;
        if (acc) begin
          if (legalCmd(int'(cmdSize), int'(cmdLocalAddr), int'(cmdSysAddr))) begin
            mBusy = 1; mRem = int'(cmdSize); mLaddr = int'(cmdLocalAddr);
            mSaddr = int'(cmdSysAddr); mTag = int'(cmdTag); mWrite = cmdWrite;
          end else mErr = 1;
        end
        chk("R5", "cmdReady", cmdReady, !mBusy);
        chk("R4", "pktValid", pktValid, mBusy && mGap == 0);
        if (mBusy && mGap == 0 && pktValid) begin
          chk("R3", "pktBytes", pktBytes, (mRem > 128) ? 128 : mRem);
          chk("R3", "pktLocalAddr", pktLocalAddr, mLaddr & 'h3FFFF);
          chk("R3", "pktSysAddr", pktSysAddr, mSaddr);
          chk("R3", "pktLast", pktLast, mRem <= 128);
          chk("R9", "pktTag", pktTag, mTag);
          chk("R9", "pktWrite", pktWrite, mWrite);
        end
        chk("R1", "cmdErr", cmdErr, mErr);
        idleExp = 0;
        for (int t = 0; t < TAGS; t++) if (mCnt[t] == 0) idleExp |= (1 << t);
        chk("R7", "tagIdle", tagIdle, unsigned'(idleExp));
        chk("R8", "waitReady", waitReady,
            waitValid && ((waitMask & ~unsigned'(idleExp)) == 0));
      end
    end
  end

  // acknowledge driver
  initial begin
    ackValid = 0; ackTag = 0;
    forever begin
      @(negedge clk);
      ackValid = 0;
      if (spurTag >= 0) begin
        ackValid = 1; ackTag = 5'(spurTag); spurTag = -1;
      end else if (ackOn && tagQ.size() > 0 && ($urandom % 3) != 0) begin
        ackValid = 1; ackTag = 5'(tagQ.pop_front());
      end
    end
  end

  // packet ready driver
  initial begin
    pktReady = 1;
    forever begin
      @(negedge clk);
      pktReady = (readyMode == 0) ? 1'b1 : 1'($urandom % 2);
    end
  end

  task automatic sendCmd(int la, int sa, int size, bit wr, int tag);
    @(negedge clk);
    cmdLocalAddr = 18'(la); cmdSysAddr = 32'(sa); cmdSize = 15'(size);
    cmdWrite = wr; cmdTag = 5'(tag); cmdValid = 1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic waitFree();
    do @(negedge clk); while (!cmdReady);
  endtask

  task automatic drain();
    ackOn = 1;
    waitFree();
    do @(negedge clk); while (tagIdle != '1 || tagQ.size() != 0);
  endtask

  initial begin
    rst_n = 0; cmdValid = 0; cmdLocalAddr = 0; cmdSysAddr = 0; cmdSize = 0;
    cmdWrite = 0; cmdTag = 0; waitValid = 0; waitMask = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "cmdReady in reset", cmdReady, 1);
    chk("R10", "pktValid in reset", pktValid, 0);
    chk("R10", "cmdErr in reset", cmdErr, 0);
    chk("R10", "tagIdle in reset", tagIdle, 32'hFFFF_FFFF);
    rst_n = 1;

    // R3 R9: single packet, odd byte
    sendCmd('h100, 'h2000, 16, 0, 1);
    chk("R1", "legal 16B no error", cmdErr, 0);
    sendCmd('h107, 'h3003, 1, 1, 2);
    chk("R2", "1B any alignment", cmdErr, 0);
    drain();

    // R1 illegal sizes
    sendCmd(0, 0, 0, 0, 3);     chk("R1", "size 0 rejected", cmdErr, 1);
    sendCmd(0, 0, 3, 0, 3);     chk("R1", "size 3 rejected", cmdErr, 1);
    sendCmd(0, 0, 24, 0, 3);    chk("R1", "size 24 rejected", cmdErr, 1);
    sendCmd(0, 0, 16400, 0, 3); chk("R1", "size 16400 rejected", cmdErr, 1);
    // R2 misalignment
    sendCmd('h3, 0, 2, 0, 4);       chk("R2", "2B odd local rejected", cmdErr, 1);
    sendCmd(0, 'h8, 32, 0, 4);      chk("R2", "32B sys low bits rejected", cmdErr, 1);
    sendCmd('h8, 'h4, 8, 1, 4);     chk("R2", "8B sys misaligned rejected", cmdErr, 1);
    sendCmd('h8, 'h18, 8, 1, 4);    chk("R2", "8B aligned accepted", cmdErr, 0);
    drain();

    // R3 R4 R6 multi-packet with stalls and acks
    readyMode = 1;
    sendCmd('h400, 'h10000, 304, 1, 6);
    sendCmd('h800, 'h20000, 256, 0, 7);
    sendCmd('h40, 'h80, 4, 0, 7);
    drain();
    readyMode = 0;

    // R8 blocking wait
    ackOn = 0;
    sendCmd('h0, 'h40000, 64, 0, 5);
    waitMask = (32'd1 << 5) | (32'd1 << 1); waitValid = 1;
    waitFree();
    repeat (3) @(negedge clk);
    chk("R8", "wait blocked on busy tag", waitReady, 0);
    drain();
    repeat (2) @(negedge clk);
    chk("R8", "wait released", waitReady, 1);
    waitValid = 0;

    // R7 spurious ack to idle tag is ignored
    ackOn = 0;
    spurTag = 31;
    repeat (3) @(negedge clk);
    chk("R7", "spurious ack tag31 idle", tagIdle[31], 1);
    sendCmd('h0, 'h0, 16, 0, 31);
    waitFree();
    chk("R7", "tag31 counts one packet", tagIdle[31], 0);
    drain();

    // R3 largest legal size, 128 packets
    sendCmd('h0, 'h100000, 16384, 1, 9);
    drain();
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule